// File: doc/BRIEF.md
# Segmented Systolic Local-Alignment Scorer

This block scores local alignments between a set of short query strings and one streamed database string. It is a one-way chain of scoring cells. Each cell holds one query symbol and computes one column of the local-alignment score matrix. Database symbols enter the head cell and move one cell further on every clock. Because of this, each anti-diagonal of the matrix is evaluated in a single cycle, and every cell delivers a new score each cycle.

The chain is divided into fixed-size segments. At each seam between two segments, a select bit decides what the first cell of the later segment receives from its left:
- the registered scores of the neighbour, so the query carries on across the seam; or
- zeros, so a fresh query begins at that cell.

Each segment reports the largest cell score it has seen since the last database start. This lets several short queries share one pass over the database. Software reads the peak of whichever segment holds the last column of each query.

A cell scores a symbol pair with a fixed reward when the two symbols are equal and a fixed penalty when they differ. Gaps use separate penalties for opening and for extending. All four values are run-time inputs.

Top module: `sw_seg_array`

## Requirements
- R1: A database symbol accepted at clock edge t is scored by cell i at edge t+i. A score from the last cell of the chain first shows in its segment's peak after edge t+NUM_PE-1.
- R2: Each cell computes a new score in the same clock edge as its input, following this recurrence:
  - H = max(Hdiag + s, E, F), where Hdiag is the left neighbour's H one row earlier.
  - E = max(Hleft - open, Eleft - extend).
  - F = max(Hup - open, Fup - extend).
  - Every value is floored at zero.
- R3: Symbols are 5-bit codes compared for full equality. The pair score s is +match when the codes are equal and -mismatch when they differ; there is no substitution table.
- R4: Scores are 16-bit unsigned. An addition that would exceed 65535 yields 65535.
- R5: Bit k of `seg_join` set makes segment k+1 continue the query of segment k. Clear, segment k+1 starts a new query with zero left and diagonal scores. Segment 0 always starts a new query.
- R6: The `seg_peak` output carries one 16-bit field per segment, with segment k in bits [16k+15:16k]. Each field equals the largest H produced by any cell of that segment since the last database start, and never decreases between starts.
- R7: A `db_start` pulse clears every score, gap, peak and in-flight symbol at the next edge. A symbol presented in the same cycle as `db_start` is discarded.
- R8: Cycles with `din_valid` low insert bubbles. They change no score, and a stream with bubbles gives the same peaks as the same stream without them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| db_start | input | 1 | Database start pulse; clears all state |
| din_valid | input | 1 | Database symbol on `din_sym` is valid |
| din_sym | input | 5 | Database symbol code |
| query_syms | input | NUM_PE*5 | Query symbol of cell i in bits [5i+4:5i] |
| seg_join | input | NUM_SEG-1 | Bit k joins segment k+1 to segment k |
| match_sc | input | 16 | Reward for equal symbols |
| mism_sc | input | 16 | Penalty for unequal symbols |
| open_pen | input | 16 | Gap-open penalty |
| ext_pen | input | 16 | Gap-extend penalty |
| seg_peak | output | NUM_SEG*16 | Per-segment peak score |

## Verification
A symbol accepted at edge t changes cell i at edge t+i. Because of this, the peak of segment k settles (k+1)*SEG_LEN-1 edges after the last accepted symbol. The timing probe samples the last segment's peak one edge before and exactly at edge t+63 of the 64-cell bench chain. Every full-stream case waits NUM_PE+2 edges after its last symbol before comparing both peaks with a bench dynamic-programming model. Clearing by `db_start` is sampled on the first falling edge after the pulse's edge. All samples are taken on falling edges, half a period away from the edges where the results change.

// File: rtl/sw_align_pkg.sv
package sw_align_pkg;
    localparam int CHAR_W  = 5;
    localparam int SCORE_W = 16;

    typedef logic [CHAR_W-1:0]  sym_t;
    typedef logic [SCORE_W-1:0] score_t;

    typedef struct packed {
        logic   vld;
        sym_t   sym;
        score_t h;
        score_t e;
        score_t f;
        score_t diag;
        score_t best;
    } cell_state_t;

    function automatic score_t sat_add(input score_t a, input score_t b);
        logic [SCORE_W:0] sum;
        sum = {1'b0, a} + {1'b0, b};
        return sum[SCORE_W] ? '1 : sum[SCORE_W-1:0];
    endfunction

    function automatic score_t sat_sub(input score_t a, input score_t b);
        return (a > b) ? a - b : '0;
    endfunction

    function automatic score_t smax(input score_t a, input score_t b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/sw_cell.sv
module sw_cell
    import sw_align_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clr,
    input  sym_t   qsym,
    input  score_t match_sc,
    input  score_t mism_sc,
    input  score_t open_pen,
    input  score_t ext_pen,
    input  logic   in_vld,
    input  sym_t   in_sym,
    input  score_t in_h,
    input  score_t in_e,
    output logic   out_vld,
    output sym_t   out_sym,
    output score_t out_h,
    output score_t out_e,
    output score_t out_best
);
    cell_state_t st_d, st_q;
    score_t      diag_sc, e_new, f_new, h_new;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        diag_sc  = (in_sym == qsym) ? sat_add(st_q.diag, match_sc)
                                    : sat_sub(st_q.diag, mism_sc);
        e_new    = smax(sat_sub(in_h, open_pen), sat_sub(in_e, ext_pen));
        f_new    = smax(sat_sub(st_q.h, open_pen), sat_sub(st_q.f, ext_pen));
        h_new    = smax(diag_sc, smax(e_new, f_new));
        if (clr) begin
            st_d = '0;
        end else if (in_vld) begin
            st_d.vld  = 1'b1;
            st_d.sym  = in_sym;
            st_d.h    = h_new;
            st_d.e    = e_new;
            st_d.f    = f_new;
            st_d.diag = in_h;
            st_d.best = smax(st_q.best, h_new);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld  = st_q.vld;
    assign out_sym  = st_q.sym;
    assign out_h    = st_q.h;
    assign out_e    = st_q.e;
    assign out_best = st_q.best;
endmodule

// File: rtl/sw_seg_peak.sv
module sw_seg_peak
    import sw_align_pkg::*;
#(
    parameter int SEG_LEN = 32
) (
    input  logic [SEG_LEN*SCORE_W-1:0] bests,
    output score_t                     peak
);
    always_comb begin
        peak = '0;
        for (int i = 0; i < SEG_LEN; i++) begin
            peak = smax(peak, bests[i*SCORE_W +: SCORE_W]);
        end
    end
endmodule

// File: rtl/sw_seg_array.sv
module sw_seg_array
    import sw_align_pkg::*;
#(
    parameter int NUM_PE  = 64,
    parameter int SEG_LEN = 32,
    localparam int NUM_SEG = NUM_PE / SEG_LEN
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      db_start,
    input  logic                      din_valid,
    input  logic [CHAR_W-1:0]         din_sym,
    input  logic [NUM_PE*CHAR_W-1:0]  query_syms,
    input  logic [NUM_SEG-2:0]        seg_join,
    input  logic [SCORE_W-1:0]        match_sc,
    input  logic [SCORE_W-1:0]        mism_sc,
    input  logic [SCORE_W-1:0]        open_pen,
    input  logic [SCORE_W-1:0]        ext_pen,
    output logic [NUM_SEG*SCORE_W-1:0] seg_peak
);
    logic [NUM_PE-1:0]         vld_vec;
    logic [NUM_PE*CHAR_W-1:0]  sym_vec;
    logic [NUM_PE*SCORE_W-1:0] h_vec, e_vec, best_vec;

    for (genvar i = 0; i < NUM_PE; i++) begin : g_pe
        logic   in_vld_w;
        sym_t   in_sym_w;
        score_t in_h_w, in_e_w;

        if (i == 0) begin : g_head
            assign in_vld_w = din_valid;
            assign in_sym_w = din_sym;
            assign in_h_w   = '0;
            assign in_e_w   = '0;
        end else if ((i % SEG_LEN) == 0) begin : g_seam
            assign in_vld_w = vld_vec[i-1];
            assign in_sym_w = sym_vec[(i-1)*CHAR_W +: CHAR_W];
            assign in_h_w   = seg_join[i/SEG_LEN-1] ? h_vec[(i-1)*SCORE_W +: SCORE_W] : '0;
            assign in_e_w   = seg_join[i/SEG_LEN-1] ? e_vec[(i-1)*SCORE_W +: SCORE_W] : '0;
        end else begin : g_mid
            assign in_vld_w = vld_vec[i-1];
            assign in_sym_w = sym_vec[(i-1)*CHAR_W +: CHAR_W];
            assign in_h_w   = h_vec[(i-1)*SCORE_W +: SCORE_W];
            assign in_e_w   = e_vec[(i-1)*SCORE_W +: SCORE_W];
        end

        sw_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (db_start),
            .qsym     (query_syms[i*CHAR_W +: CHAR_W]),
            .match_sc (match_sc),
            .mism_sc  (mism_sc),
            .open_pen (open_pen),
            .ext_pen  (ext_pen),
            .in_vld   (in_vld_w),
            .in_sym   (in_sym_w),
            .in_h     (in_h_w),
            .in_e     (in_e_w),
            .out_vld  (vld_vec[i]),
            .out_sym  (sym_vec[i*CHAR_W +: CHAR_W]),
            .out_h    (h_vec[i*SCORE_W +: SCORE_W]),
            .out_e    (e_vec[i*SCORE_W +: SCORE_W]),
            .out_best (best_vec[i*SCORE_W +: SCORE_W])
        );
    end

    for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
        sw_seg_peak #(.SEG_LEN(SEG_LEN)) u_peak (
            .bests (best_vec[k*SEG_LEN*SCORE_W +: SEG_LEN*SCORE_W]),
            .peak  (seg_peak[k*SCORE_W +: SCORE_W])
        );
    end
endmodule

// File: rtl/sw_seg_array_chk.sv
module sw_seg_array_chk
    import sw_align_pkg::*;
#(
    parameter int NUM_PE  = 64,
    parameter int SEG_LEN = 32,
    localparam int NUM_SEG = NUM_PE / SEG_LEN
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       db_start,
    input logic                       din_valid,
    input logic [NUM_PE-1:0]          vld_vec,
    input logic [NUM_PE*CHAR_W-1:0]   sym_vec,
    input logic [NUM_SEG*SCORE_W-1:0] seg_peak
);
    AST_START_CLEARS_PEAKS: assert property (@(posedge clk) disable iff (!rst_n)
        db_start |=> (seg_peak == '0)); // R7

    AST_START_DROPS_SYMBOL: assert property (@(posedge clk) disable iff (!rst_n)
        db_start |=> !vld_vec[0]); // R7

    AST_BUBBLE_HOLDS_PEAKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!db_start && !din_valid && (vld_vec[NUM_PE-2:0] == '0)) |=> $stable(seg_peak)); // R8

    for (genvar k = 0; k < NUM_SEG; k++) begin : g_mono
        AST_PEAK_NEVER_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
            !db_start |=> (seg_peak[k*SCORE_W +: SCORE_W] >= $past(seg_peak[k*SCORE_W +: SCORE_W]))); // R6
    end

    for (genvar i = 0; i < NUM_PE-1; i++) begin : g_shift
        AST_SYMBOL_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
            (!db_start && vld_vec[i]) |=>
            (vld_vec[i+1] && (sym_vec[(i+1)*CHAR_W +: CHAR_W] == $past(sym_vec[i*CHAR_W +: CHAR_W])))); // R1
    end
endmodule

bind sw_seg_array sw_seg_array_chk #(.NUM_PE(NUM_PE), .SEG_LEN(SEG_LEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .db_start  (db_start),
    .din_valid (din_valid),
    .vld_vec   (vld_vec),
    .sym_vec   (sym_vec),
    .seg_peak  (seg_peak)
);

// File: tb/sw_seg_array_bench.sv
module sw_seg_array_bench;
    localparam int NPE  = 64;
    localparam int SEG  = 32;
    localparam int NSEG = NPE / SEG;
    localparam int SMAX = 65535;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic db_start = 1'b0;
    logic din_valid = 1'b0;
    logic [4:0] din_sym = '0;
    logic [NPE*5-1:0] query_syms = '0;
    logic [NSEG-2:0] seg_join = '0;
    logic [15:0] match_sc = 16'd2, mism_sc = 16'd1, open_pen = 16'd3, ext_pen = 16'd1;
    logic [NSEG*16-1:0] seg_peak;

    int checks = 0;
    int errors = 0;
    int lfsr = 32'h1234_5678;
    int qa [NPE];
    int dba [64];

    always #4 clk = ~clk;

    sw_seg_array #(.NUM_PE(NPE), .SEG_LEN(SEG)) u_sw_seg_array (
        .clk(clk), .rst_n(rst_n), .db_start(db_start), .din_valid(din_valid),
        .din_sym(din_sym), .query_syms(query_syms), .seg_join(seg_join),
        .match_sc(match_sc), .mism_sc(mism_sc), .open_pen(open_pen),
        .ext_pen(ext_pen), .seg_peak(seg_peak));

    function automatic int clampv(input int x);
        return (x < 0) ? 0 : ((x > SMAX) ? SMAX : x);
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int rnd();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >>> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return lfsr & 32'h7fff_ffff;
    endfunction

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        db_start = 1'b1;
        din_valid = 1'b0;
        @(negedge clk);
        db_start = 1'b0;
    endtask

    // Bench model of the recurrence, using only the requirement text
    task automatic model(input int len, output int pk [NSEG]);
        int hp [NPE], fp [NPE], hc [NPE], ec [NPE];
        for (int i = 0; i < NPE; i++) begin
            hp[i] = 0;
            fp[i] = 0;
        end
        for (int k = 0; k < NSEG; k++) pk[k] = 0;
        for (int j = 0; j < len; j++) begin
            for (int i = 0; i < NPE; i++) begin
                bit fresh;
                int hl, el, dg, s, e, f, h;
                fresh = (i == 0) || ((i % SEG) == 0 && !seg_join[i/SEG-1]);
                hl = fresh ? 0 : hc[i-1];
                el = fresh ? 0 : ec[i-1];
                dg = fresh ? 0 : hp[i-1];
                s  = (dba[j] == qa[i]) ? clampv(dg + int'(match_sc)) : clampv(dg - int'(mism_sc));
                e  = imax(clampv(hl - int'(open_pen)), clampv(el - int'(ext_pen)));
                f  = imax(clampv(hp[i] - int'(open_pen)), clampv(fp[i] - int'(ext_pen)));
                h  = imax(s, imax(e, f));
                hc[i] = h;
                ec[i] = e;
                fp[i] = f;
                pk[i/SEG] = imax(pk[i/SEG], h);
            end
            for (int i = 0; i < NPE; i++) hp[i] = hc[i];
        end
    endtask

    task automatic run_case(input string req, input int join_v, input int alph, input int len,
                            input int m, input int mm, input int op, input int ex, input bit bubbles);
        int pk [NSEG];
        seg_join = join_v[NSEG-2:0];
        match_sc = m[15:0];
        mism_sc  = mm[15:0];
        open_pen = op[15:0];
        ext_pen  = ex[15:0];
        for (int i = 0; i < NPE; i++) begin
            qa[i] = rnd() % alph;
            query_syms[i*5 +: 5] = qa[i][4:0];
        end
        for (int j = 0; j < len; j++) dba[j] = rnd() % alph;
        pulse_start();
        for (int j = 0; j < len; j++) begin
            if (bubbles && (j % 3 == 1)) begin
                din_valid = 1'b0;
                @(negedge clk);
            end
            din_valid = 1'b1;
            din_sym = dba[j][4:0];
            @(negedge clk);
        end
        din_valid = 1'b0;
        repeat (NPE + 2) @(negedge clk);
        model(len, pk);
        for (int k = 0; k < NSEG; k++) check(req, int'(seg_peak[k*16 +: 16]), pk[k]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R6 reset peak0", int'(seg_peak[15:0]), 0);
        check("R6 reset peak1", int'(seg_peak[31:16]), 0);
        rst_n = 1'b1;

        // R1: one symbol, matching only the last cell
        for (int i = 0; i < NPE; i++) query_syms[i*5 +: 5] = 5'd3;
        query_syms[(NPE-1)*5 +: 5] = 5'd2;
        seg_join = '0;
        match_sc = 16'd7;
        mism_sc = 16'd1;
        open_pen = 16'd3;
        ext_pen = 16'd1;
        pulse_start();
        din_valid = 1'b1;
        din_sym = 5'd2;
        @(negedge clk);
        din_valid = 1'b0;
        repeat (62) @(negedge clk);
        check("R1 before arrival", int'(seg_peak[31:16]), 0);
        @(negedge clk);
        check("R1 at arrival", int'(seg_peak[31:16]), 7);
        check("R3 mismatch column", int'(seg_peak[15:0]), 0);

        // R7: clearing, and a symbol presented with the start pulse is dropped
        pulse_start();
        check("R7 cleared", int'(seg_peak[31:16]), 0);
        @(negedge clk);
        db_start = 1'b1;
        din_valid = 1'b1;
        din_sym = 5'd2;
        @(negedge clk);
        db_start = 1'b0;
        din_valid = 1'b0;
        repeat (NPE + 2) @(negedge clk);
        check("R7 dropped symbol", int'(seg_peak[31:16]), 0);

        // R2/R3/R5/R6: model sweeps over joins, alphabets and penalties
        for (int jn = 0; jn < 2; jn++) begin
            run_case(jn ? "R5 joined R2" : "R5 split R2", jn, 4, 40, 2, 1, 3, 1, 1'b0);
            run_case("R3 wide alphabet", jn, 26, 48, 5, 4, 6, 2, 1'b0);
            run_case("R2 affine gaps", jn, 3, 36, 3, 2, 2, 1, 1'b0);
            run_case("R6 small gap penalties", jn, 2, 30, 1, 1, 1, 0, 1'b0);
        end

        // R8: bubbles give the same result as the model of the dense stream
        run_case("R8 bubbles", 1, 4, 40, 2, 1, 3, 1, 1'b1);
        run_case("R8 bubbles split", 0, 5, 33, 4, 2, 5, 1, 1'b1);

        // R4: saturation at the top of the score range
        run_case("R4 saturation", 1, 1, 6, 40000, 1, 3, 1, 1'b0);
        check("R4 clamp value", int'(seg_peak[31:16]), SMAX);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule